// File: doc/BRIEF.md
# Counting Semaphore Blocking Unit

This block keeps a small table of counting semaphores in hardware. Each entry holds an allocation flag, a signed count and a first-in first-out queue of blocked process indices. The queues are not stored per entry: every queue is threaded through one link table that is shared by all entries and indexed by process number. Next to the link table is a priority table that records the priority of each blocked process.

Requests arrive on a valid/ready stream. A request carries an operation, a semaphore index, a process index, a priority and an initial value. The unit accepts at most one request per cycle and answers it one cycle later on a valid/ready response stream.

The response tells an external scheduler three things: whether to take the processor away from the caller, which process index (and its priority) to move to the ready state, and whether the request was refused. Back-pressure works through a single response register. A request is accepted only while that register is empty or is being drained in the same cycle, so `req_ready` is high exactly when `rsp_valid` is low or `rsp_ready` is high. A response waiting on a low `rsp_ready` keeps every field unchanged.

Top module: `sem_block_unit`

## Requirements
- R1: After reset every semaphore is unallocated and no response is pending: `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` equals `!rsp_valid || rsp_ready`. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response is valid on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value.
- R3: Operation code 0 (create) on an unallocated entry allocates it with count equal to `req_init` and an empty queue. Create on an entry that is already allocated sets `rsp_err` and changes nothing.
- R4: Operation code 2 (wait) lowers the count by one. If the result is zero or more, no switch and no wake are reported.
- R5: If the count after a wait is negative, the caller's index and priority are appended to the tail of that semaphore's queue, and `rsp_switch` is 1.
- R6: Operation code 3 (signal) raises the count by one. If the result is positive, no wake and no switch are reported.
- R7: If the count after a signal is zero or less, the head of that semaphore's queue is removed and reported on `rsp_wake_proc`, with `rsp_wake` at 1 and `rsp_wake_prio` set to the priority the process gave when it blocked. Processes wake in the order they blocked.
- R8: After a signal that wakes a process, `rsp_switch` is 1 exactly when the woken priority is numerically less than the sender's `req_prio`. Equal priorities give no switch.
- R9: Wait, signal or operation code 1 (delete) on an unallocated entry sets `rsp_err`, with `rsp_switch` and `rsp_wake` both 0, and leaves all state unchanged.
- R10: Delete on an entry whose queue holds blocked processes sets `rsp_err` and leaves the entry intact. Delete on an entry with an empty queue frees it.
- R11: A wait from process index 0 sets `rsp_err` and queues nothing. A woken index is never 0.
- R12: The queues of different semaphores are independent, even though they share one link table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | 0 create, 1 delete, 2 wait, 3 signal |
| req_sem | input | $clog2(N_SEM) | Semaphore index |
| req_proc | input | $clog2(N_PROC) | Caller process index (used by wait) |
| req_prio | input | PRIO_W | Caller priority on wait, sender priority on signal; lower number is more urgent |
| req_init | input | CNT_W-1 | Initial non-negative count for create |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response this cycle |
| rsp_switch | output | 1 | Scheduler should switch away from the requester |
| rsp_wake | output | 1 | A process is to be made ready |
| rsp_wake_proc | output | $clog2(N_PROC) | Index of the woken process |
| rsp_wake_prio | output | PRIO_W | Priority of the woken process |
| rsp_err | output | 1 | Request refused; no state changed |

## Verification
A wrong count shows up at the ports on the first signal or wait that crosses zero. A wait then blocks when it should not, or a signal wakes nothing when it should wake a process, or the reverse. A broken link or tail pointer shows up only when a queue is drained: a process wakes out of order, an index is repeated, or an index of zero is reported. This can happen many requests after the fault itself, so the bench builds deep queues on more than one semaphore before draining them. A wrong allocation flag shows up on the next request to that entry as a missing or spurious `rsp_err`.

// File: rtl/sem_unit_pkg.sv
package sem_unit_pkg;
  typedef enum logic [1:0] {
    OP_CREATE = 2'd0,
    OP_DELETE = 2'd1,
    OP_WAIT   = 2'd2,
    OP_SIGNAL = 2'd3
  } sem_op_e;
endpackage

// File: rtl/sem_unit_entries.sv
// Per-semaphore state: allocation flag, signed count, queue head and tail.
module sem_unit_entries #(
  parameter int N_SEM  = 4,
  parameter int CNT_W  = 6,
  parameter int PROC_W = 4,
  parameter int SEM_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SEM_W-1:0]        idx,
  output logic                    rd_alloc,
  output logic signed [CNT_W-1:0] rd_cnt,
  output logic [PROC_W-1:0]       rd_head,
  output logic [PROC_W-1:0]       rd_tail,
  input  logic                    we,
  input  logic                    wr_alloc,
  input  logic signed [CNT_W-1:0] wr_cnt,
  input  logic [PROC_W-1:0]       wr_head,
  input  logic [PROC_W-1:0]       wr_tail
);
  logic                    alloc_q [N_SEM];
  logic signed [CNT_W-1:0] cnt_q   [N_SEM];
  logic [PROC_W-1:0]       head_q  [N_SEM];
  logic [PROC_W-1:0]       tail_q  [N_SEM];

  for (genvar g = 0; g < N_SEM; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        alloc_q[g] <= 1'b0;
        cnt_q[g]   <= '0;
        head_q[g]  <= '0;
        tail_q[g]  <= '0;
      end else if (we && idx == SEM_W'(g)) begin
        alloc_q[g] <= wr_alloc;
        cnt_q[g]   <= wr_cnt;
        head_q[g]  <= wr_head;
        tail_q[g]  <= wr_tail;
      end
    end
  end

  assign rd_alloc = alloc_q[idx];
  assign rd_cnt   = cnt_q[idx];
  assign rd_head  = head_q[idx];
  assign rd_tail  = tail_q[idx];
endmodule

// File: rtl/sem_unit_links.sv
// Shared link table and blocked-priority table, both indexed by process.
module sem_unit_links #(
  parameter int N_PROC = 16,
  parameter int PROC_W = 4,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              link_we,
  input  logic [PROC_W-1:0] link_addr,
  input  logic [PROC_W-1:0] link_data,
  input  logic              prio_we,
  input  logic [PROC_W-1:0] prio_addr,
  input  logic [PRIO_W-1:0] prio_data,
  input  logic [PROC_W-1:0] rd_addr,
  output logic [PROC_W-1:0] rd_link,
  output logic [PRIO_W-1:0] rd_prio
);
  logic [PROC_W-1:0] link_mem [N_PROC];
  logic [PRIO_W-1:0] prio_mem [N_PROC];

  always_ff @(posedge clk) begin
    if (link_we) link_mem[link_addr] <= link_data;
    if (prio_we) prio_mem[prio_addr] <= prio_data;
  end

  assign rd_link = link_mem[rd_addr];
  assign rd_prio = prio_mem[rd_addr];
endmodule

// File: rtl/sem_unit_ctrl.sv
// Combinational decision: next entry state, table writes and response flags.
module sem_unit_ctrl
  import sem_unit_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int PROC_W = 4,
  parameter int PRIO_W = 3
) (
  input  sem_op_e                 op,
  input  logic [PROC_W-1:0]       proc,
  input  logic [PRIO_W-1:0]       prio,
  input  logic [CNT_W-2:0]        init,
  input  logic                    cur_alloc,
  input  logic signed [CNT_W-1:0] cur_cnt,
  input  logic [PROC_W-1:0]       cur_head,
  input  logic [PROC_W-1:0]       cur_tail,
  input  logic [PROC_W-1:0]       head_link,
  input  logic [PRIO_W-1:0]       head_prio,
  output logic                    ent_we,
  output logic                    nxt_alloc,
  output logic signed [CNT_W-1:0] nxt_cnt,
  output logic [PROC_W-1:0]       nxt_head,
  output logic [PROC_W-1:0]       nxt_tail,
  output logic                    link_we,
  output logic                    prio_we,
  output logic                    o_switch,
  output logic                    o_wake,
  output logic [PROC_W-1:0]       o_wake_proc,
  output logic [PRIO_W-1:0]       o_wake_prio,
  output logic                    o_err
);
  localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

  logic signed [CNT_W-1:0] cnt_dec, cnt_inc;
  logic                    q_empty, q_single;

  assign cnt_dec  = cur_cnt - ONE;
  assign cnt_inc  = cur_cnt + ONE;
  assign q_empty  = (cur_head == '0);
  assign q_single = (cur_head == cur_tail);

  always_comb begin
    ent_we      = 1'b0;
    nxt_alloc   = cur_alloc;
    nxt_cnt     = cur_cnt;
    nxt_head    = cur_head;
    nxt_tail    = cur_tail;
    link_we     = 1'b0;
    prio_we     = 1'b0;
    o_switch    = 1'b0;
    o_wake      = 1'b0;
    o_wake_proc = '0;
    o_wake_prio = '0;
    o_err       = 1'b0;
    unique case (op)
      OP_CREATE: begin
        if (cur_alloc) o_err = 1'b1;
        else begin
          ent_we    = 1'b1;
          nxt_alloc = 1'b1;
          nxt_cnt   = $signed({1'b0, init});
          nxt_head  = '0;
          nxt_tail  = '0;
        end
      end
      OP_DELETE: begin
        if (!cur_alloc || !q_empty) o_err = 1'b1;
        else begin
          ent_we    = 1'b1;
          nxt_alloc = 1'b0;
          nxt_cnt   = '0;
        end
      end
      OP_WAIT: begin
        if (!cur_alloc || proc == '0) o_err = 1'b1;
        else begin
          ent_we  = 1'b1;
          nxt_cnt = cnt_dec;
          if (cnt_dec[CNT_W-1]) begin
            o_switch = 1'b1;
            prio_we  = 1'b1;
            nxt_tail = proc;
            if (q_empty) nxt_head = proc;
            else         link_we  = 1'b1;
          end
        end
      end
      OP_SIGNAL: begin
        if (!cur_alloc) o_err = 1'b1;
        else begin
          ent_we  = 1'b1;
          nxt_cnt = cnt_inc;
          if ((cnt_inc[CNT_W-1] || cnt_inc == '0) && !q_empty) begin
            o_wake      = 1'b1;
            o_wake_proc = cur_head;
            o_wake_prio = head_prio;
            o_switch    = (head_prio < prio);
            nxt_head    = q_single ? '0 : head_link;
            nxt_tail    = q_single ? '0 : cur_tail;
          end
        end
      end
      default: o_err = 1'b1;
    endcase
  end
endmodule

// File: rtl/sem_block_unit.sv
module sem_block_unit
  import sem_unit_pkg::*;
#(
  parameter int N_SEM  = 4,
  parameter int N_PROC = 16,
  parameter int PRIO_W = 3,
  parameter int CNT_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [1:0]                 req_op,
  input  logic [$clog2(N_SEM)-1:0]   req_sem,
  input  logic [$clog2(N_PROC)-1:0]  req_proc,
  input  logic [PRIO_W-1:0]          req_prio,
  input  logic [CNT_W-2:0]           req_init,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic                       rsp_switch,
  output logic                       rsp_wake,
  output logic [$clog2(N_PROC)-1:0]  rsp_wake_proc,
  output logic [PRIO_W-1:0]          rsp_wake_prio,
  output logic                       rsp_err
);
  localparam int SEM_W  = $clog2(N_SEM);
  localparam int PROC_W = $clog2(N_PROC);

  logic                    fire;
  logic                    cur_alloc;
  logic signed [CNT_W-1:0] cur_cnt;
  logic [PROC_W-1:0]       cur_head, cur_tail, head_link;
  logic [PRIO_W-1:0]       head_prio;
  logic                    ent_we, nxt_alloc, link_we, prio_we;
  logic signed [CNT_W-1:0] nxt_cnt;
  logic [PROC_W-1:0]       nxt_head, nxt_tail;
  logic                    d_switch, d_wake, d_err;
  logic [PROC_W-1:0]       d_wake_proc;
  logic [PRIO_W-1:0]       d_wake_prio;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  sem_unit_entries #(
    .N_SEM(N_SEM), .CNT_W(CNT_W), .PROC_W(PROC_W), .SEM_W(SEM_W)
  ) u_entries (
    .clk(clk), .rst(rst), .idx(req_sem),
    .rd_alloc(cur_alloc), .rd_cnt(cur_cnt), .rd_head(cur_head), .rd_tail(cur_tail),
    .we(fire && ent_we), .wr_alloc(nxt_alloc), .wr_cnt(nxt_cnt),
    .wr_head(nxt_head), .wr_tail(nxt_tail)
  );

  sem_unit_links #(
    .N_PROC(N_PROC), .PROC_W(PROC_W), .PRIO_W(PRIO_W)
  ) u_links (
    .clk(clk),
    .link_we(fire && link_we), .link_addr(cur_tail), .link_data(req_proc),
    .prio_we(fire && prio_we), .prio_addr(req_proc), .prio_data(req_prio),
    .rd_addr(cur_head), .rd_link(head_link), .rd_prio(head_prio)
  );

  sem_unit_ctrl #(
    .CNT_W(CNT_W), .PROC_W(PROC_W), .PRIO_W(PRIO_W)
  ) u_ctrl (
    .op(sem_op_e'(req_op)), .proc(req_proc), .prio(req_prio), .init(req_init),
    .cur_alloc(cur_alloc), .cur_cnt(cur_cnt), .cur_head(cur_head), .cur_tail(cur_tail),
    .head_link(head_link), .head_prio(head_prio),
    .ent_we(ent_we), .nxt_alloc(nxt_alloc), .nxt_cnt(nxt_cnt),
    .nxt_head(nxt_head), .nxt_tail(nxt_tail),
    .link_we(link_we), .prio_we(prio_we),
    .o_switch(d_switch), .o_wake(d_wake), .o_wake_proc(d_wake_proc),
    .o_wake_prio(d_wake_prio), .o_err(d_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_switch    <= 1'b0;
      rsp_wake      <= 1'b0;
      rsp_wake_proc <= '0;
      rsp_wake_prio <= '0;
      rsp_err       <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_switch    <= d_switch;
        rsp_wake      <= d_wake;
        rsp_wake_proc <= d_wake_proc;
        rsp_wake_prio <= d_wake_prio;
        rsp_err       <= d_err;
      end
    end
  end
endmodule

// File: rtl/sem_block_unit_chk.sv
module sem_block_unit_chk
  import sem_unit_pkg::*;
#(
  parameter int PROC_W = 4,
  parameter int PRIO_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_switch,
  input logic              rsp_wake,
  input logic [PROC_W-1:0] rsp_wake_proc,
  input logic [PRIO_W-1:0] rsp_wake_prio,
  input logic              rsp_err
);
  logic [1:0] acc_op;

  always_ff @(posedge clk) begin
    if (rst) acc_op <= 2'd0;
    else if (req_valid && req_ready) acc_op <= req_op;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !rsp_valid); // R1

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |-> !req_ready); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_switch) && $stable(rsp_wake)
      && $stable(rsp_wake_proc) && $stable(rsp_wake_prio) && $stable(rsp_err)); // R2

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> !rsp_switch && !rsp_wake); // R9

  AST_WAKE_FROM_SIGNAL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_wake |-> acc_op == OP_SIGNAL); // R7

  AST_SWITCH_SOURCE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_switch |-> (acc_op == OP_WAIT || acc_op == OP_SIGNAL)); // R5

  AST_WAKE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_wake |-> rsp_wake_proc != '0); // R11
endmodule

bind sem_block_unit sem_block_unit_chk #(
  .PROC_W($clog2(N_PROC)), .PRIO_W(PRIO_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_switch(rsp_switch),
  .rsp_wake(rsp_wake), .rsp_wake_proc(rsp_wake_proc), .rsp_wake_prio(rsp_wake_prio),
  .rsp_err(rsp_err)
);

// File: tb/sem_block_unit_test.sv
module sem_block_unit_test;
  localparam int N_SEM = 4, N_PROC = 16, PRIO_W = 3, CNT_W = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_op = '0;
  logic [1:0] req_sem = '0;
  logic [3:0] req_proc = '0;
  logic [2:0] req_prio = '0;
  logic [4:0] req_init = '0;
  logic req_ready, rsp_valid, rsp_switch, rsp_wake, rsp_err;
  logic [3:0] rsp_wake_proc;
  logic [2:0] rsp_wake_prio;

  sem_block_unit #(.N_SEM(N_SEM), .N_PROC(N_PROC), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_sem(req_sem), .req_proc(req_proc), .req_prio(req_prio), .req_init(req_init),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_switch(rsp_switch),
    .rsp_wake(rsp_wake), .rsp_wake_proc(rsp_wake_proc), .rsp_wake_prio(rsp_wake_prio),
    .rsp_err(rsp_err)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  bit m_alloc [N_SEM];
  int m_cnt   [N_SEM];
  int m_q     [N_SEM][$];
  int m_prio  [N_PROC];
  bit e_valid = 0, e_sw = 0, e_wake = 0, e_err = 0;
  int e_wp = 0, e_wpr = 0;
  string e_tag = "R1";

  task automatic cyc(input string tag, input bit v, input int op, input int sem,
                     input int proc, input int prio, input int init, input bit rdy,
                     output bit acc);
    bit ok;
    @(negedge clk);
    ok = (rsp_valid === e_valid);
    if (e_valid)
      ok = ok && (rsp_switch === e_sw) && (rsp_wake === e_wake) && (rsp_err === e_err)
              && (!e_wake || (int'(rsp_wake_proc) == e_wp && int'(rsp_wake_prio) == e_wpr));
    req_valid = v; req_op = 2'(op); req_sem = 2'(sem); req_proc = 4'(proc);
    req_prio = 3'(prio); req_init = 5'(init); rsp_ready = rdy;
    #1;
    ok = ok && (req_ready === (!e_valid || rdy));
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (ready %s): got v=%0b sw=%0b wk=%0b p=%0d pr=%0d err=%0b rdy=%0b exp v=%0b sw=%0b wk=%0b p=%0d pr=%0d err=%0b rdy=%0b",
               e_tag, tag, rsp_valid, rsp_switch, rsp_wake, rsp_wake_proc, rsp_wake_prio,
               rsp_err, req_ready, e_valid, e_sw, e_wake, e_wp, e_wpr, e_err, (!e_valid || rdy));
    end
    acc = v && (!e_valid || rdy);
    if (e_valid && !rdy) begin
      // response held
    end else if (acc) begin
      e_valid = 1; e_sw = 0; e_wake = 0; e_err = 0; e_wp = 0; e_wpr = 0; e_tag = tag;
      case (op)
        0: if (m_alloc[sem]) e_err = 1;
           else begin m_alloc[sem] = 1; m_cnt[sem] = init; m_q[sem].delete(); end
        1: if (!m_alloc[sem] || m_q[sem].size() != 0) e_err = 1;
           else begin m_alloc[sem] = 0; m_cnt[sem] = 0; end
        2: if (!m_alloc[sem] || proc == 0) e_err = 1;
           else begin
             m_cnt[sem]--;
             if (m_cnt[sem] < 0) begin
               m_q[sem].push_back(proc); m_prio[proc] = prio; e_sw = 1;
             end
           end
        default: if (!m_alloc[sem]) e_err = 1;
           else begin
             m_cnt[sem]++;
             if (m_cnt[sem] <= 0) begin
               e_wp = m_q[sem].pop_front(); e_wake = 1; e_wpr = m_prio[e_wp];
               e_sw = (e_wpr < prio);
             end
           end
      endcase
    end else e_valid = 0;
  endtask

  task automatic req(input string tag, input int op, input int sem, input int proc,
                     input int prio, input int init);
    bit a = 0;
    while (!a) cyc(tag, 1, op, sem, proc, prio, init, 1, a);
  endtask

  task automatic idle(input string tag);
    bit a;
    cyc(tag, 0, 0, 0, 0, 0, 0, 1, a);
  endtask

  function automatic bit queued(input int p);
    for (int s = 0; s < N_SEM; s++)
      foreach (m_q[s][k]) if (m_q[s][k] == p) return 1;
    return 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2: got no finish, exp finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    repeat (3) @(negedge clk);
    rst = 0;
    idle("R1");                                   // R1: nothing pending
    for (int s = 0; s < N_SEM; s++) req("R1", 2, s, 1, 0, 0); // all unallocated
    req("R9", 3, 2, 0, 0, 0);                     // R9 signal unallocated
    req("R9", 1, 0, 0, 0, 0);                     // R9 delete unallocated
    req("R3", 0, 0, 0, 0, 2);                     // R3 create
    req("R3", 0, 0, 0, 0, 9);                     // R3 duplicate create refused
    req("R4", 2, 0, 3, 5, 0);                     // R4 count 2->1
    req("R4", 2, 0, 7, 5, 0);                     // R4 count 1->0
    req("R5", 2, 0, 4, 2, 0);                     // R5 block
    req("R5", 2, 0, 5, 6, 0);                     // R5 block behind
    req("R11", 2, 0, 0, 1, 0);                    // R11 proc 0 refused
    req("R12", 0, 1, 0, 0, 0);
    req("R12", 2, 1, 6, 1, 0);                    // R12 separate queue
    req("R12", 2, 0, 8, 4, 0);
    req("R10", 1, 0, 0, 0, 0);                    // R10 delete busy refused
    req("R8", 3, 0, 0, 3, 0);                     // R8 wakes 4 prio 2 < 3
    req("R12", 3, 1, 0, 1, 0);                    // R12 wakes 6, R8 equal prio
    req("R7", 3, 0, 0, 3, 0);                     // R7 FIFO: wakes 5
    req("R7", 3, 0, 0, 7, 0);                     // R7 wakes 8
    req("R6", 3, 0, 0, 3, 0);                     // R6 count positive
    // R2: stall the response of a wait for several cycles
    req("R2", 2, 0, 9, 1, 0);
    for (int i = 0; i < 4; i++) cyc("R2", 1, 3, 0, 0, 0, 0, 0, a);
    cyc("R2", 1, 3, 0, 0, 0, 0, 1, a);
    req("R10", 1, 0, 0, 0, 0);                    // R10 delete empty frees
    req("R9", 2, 0, 2, 0, 0);                     // R9 now unallocated
    req("R9", 3, 0, 0, 0, 0);
    req("R3", 0, 0, 0, 0, 31);                    // R3 recreate at max init
    idle("R2");
    // mixed traffic with random back-pressure
    for (int i = 0; i < 3000; i++) begin
      int s, op, p;
      bit got;
      s = $urandom_range(N_SEM - 1);
      op = $urandom_range(3);
      p = $urandom_range(N_PROC - 1);
      if (op == 2 && (p == 0 || queued(p))) op = 3;
      if (op == 3 && m_alloc[s] && m_cnt[s] > 20) op = 2;
      if (op == 2 && (p == 0 || queued(p))) op = 1;
      got = 0;
      while (!got)
        cyc("R12", 1, op, s, p, $urandom_range(7), $urandom_range(7),
            1'($urandom_range(3) != 0), got);
    end
    idle("R2");
    idle("R2");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule